// File: doc/BRIEF.md
# Shadowed Method Register File

This block is a register file driven by a command stream. Each accepted method carries a register index and a 32-bit argument. Every write goes through a shadow bank that has the same size as the live bank. A mode register decides how the shadow bank takes part in the write:

- **Record:** the argument is copied into the shadow bank.
- **Record with filter:** behaves exactly like record.
- **Bypass:** the shadow bank is not touched.
- **Replay:** the stored shadow value replaces the argument before it reaches the live bank.

The value that actually lands in the live bank is the effective argument. It is also sent downstream, one cycle later, to the handlers that carry out side effects, so those handlers act on replayed data whenever replay is active.

A live register is rewritten only when the effective argument differs from its current contents. A rewrite also sets that register's dirty bit. Consumers clear dirty bits one at a time through a clear vector, and they read live state through a combinational read port. An index outside the register space changes nothing and raises a one-cycle error pulse.

Top module: `shadow_method_regfile`

## Requirements
- R1: A synchronous active-low reset does all of the following:
  - Loads every live register with its default value: 0 for index 73, and 0xC0DE0000 plus the index for every other register.
  - Loads the shadow bank with an identical copy of those defaults.
  - Sets the mode to 0 (record).
  - Clears every dirty bit.
  - Holds `err` and `out_valid` low.
- R2: In mode 0 (record) and mode 1 (record with filter), which behave identically, the incoming argument is written into the shadow bank at the same index and is also the effective argument.
- R3: In mode 2 (bypass), the shadow bank is unchanged and the incoming argument is the effective argument.
- R4: In mode 3 (replay), the incoming argument is discarded and the effective argument is the shadow value at that index.
- R5: The live register at the index, and its dirty bit, are written only when the effective argument differs from the current live value. A write with an equal value leaves both unchanged.
- R6: A method to index 73 loads its raw incoming argument into the 32-bit mode field, even while replay is active. Any mode value other than 0, 1 or 3 behaves as bypass.
- R7: One cycle after an in-range method is accepted:
  - `out_valid` is high for one cycle.
  - `out_idx` holds the method's index.
  - `out_arg` holds the effective argument.
  - Back-to-back methods give back-to-back results.
- R8: A method whose index is at or above the register count (96) changes no state, produces no `out_valid`, and raises `err` for exactly one cycle, one cycle after acceptance.
- R9: `dirty_clr[i]` clears dirty bit i at the next edge. If a change is recorded for register i in the same cycle, the set wins over the clear.
- R10: `in_ready` is high in every cycle after reset, so one method can be accepted per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A method is offered |
| in_ready | output | 1 | A method can be accepted |
| in_idx | input | 8 | Register index of the method |
| in_arg | input | 32 | Raw method argument |
| out_valid | output | 1 | Effective-argument strobe |
| out_idx | output | 8 | Index that goes with `out_arg` |
| out_arg | output | 32 | Effective argument for the side-effect handlers |
| err | output | 1 | One-cycle pulse for an out-of-range index |
| dirty | output | 96 | One dirty bit per live register |
| dirty_clr | input | 96 | Per-bit clear of the dirty bits |
| rd_idx | input | 8 | Live read index |
| rd_data | output | 32 | Live register at `rd_idx`, or 0 when out of range |

## Verification
The assertions assume that `in_idx` and `in_arg` carry known values whenever `in_valid` is high. They also assume that a mode change takes effect only for the methods that follow it. The stimulus respects both conditions: it drives every field on the falling edge, holds `in_valid` low between methods (except in the deliberate back-to-back case), and never changes mode and uses the new mode in the same method.

The vector table orders its mode writes so that each mode is exercised against shadow contents that are already known. These contents come from reset defaults or from earlier recorded writes.

// File: rtl/smrf_pkg.sv
// Package: shared types and reset defaults for the shadowed method register file.
// Assumes 32-bit register words.
package smrf_pkg;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        SHM_RECORD      = 2'd0,
        SHM_RECORD_FILT = 2'd1,
        SHM_BYPASS      = 2'd2,
        SHM_REPLAY      = 2'd3
    } shadow_mode_e;

    // Reset value of a register: the mode index resets to 0, every other index to a tagged pattern.
    function automatic logic [DATA_W-1:0] reg_default(input int idx, input int mode_idx);
        if (idx == mode_idx) return '0;
        return 32'hC0DE_0000 + DATA_W'(idx);
    endfunction

    // Decode the raw 32-bit mode field; every unknown value maps to bypass.
    function automatic shadow_mode_e decode_mode(input logic [DATA_W-1:0] raw);
        case (raw)
            32'd0:   return SHM_RECORD;
            32'd1:   return SHM_RECORD_FILT;
            32'd3:   return SHM_REPLAY;
            default: return SHM_BYPASS;
        endcase
    endfunction
endpackage

// File: rtl/smrf_mode_ctl.sv
// Module: holds the raw 32-bit shadow mode field and its decoded behaviour.
// Assumes wr_en is only raised for accepted, in-range methods that target the mode index.
module smrf_mode_ctl
    import smrf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_raw,
    output logic [DATA_W-1:0] mode_raw,
    output shadow_mode_e      mode
);
    // Capture the raw argument of a mode write.
    always_ff @(posedge clk) begin
        if (!rst_n)     mode_raw <= '0;
        else if (wr_en) mode_raw <= wr_raw;
    end

    // Translate the stored field into one of the four behaviours.
    always_comb mode = decode_mode(mode_raw);
endmodule

// File: rtl/smrf_shadow_bank.sv
// Module: shadow copy of the register space, with one write port and one read port.
// Assumes indices are already range-checked; reset loads the same defaults as the live bank.
module smrf_shadow_bank
    import smrf_pkg::*;
#(
    parameter int NUM_REGS = 96,
    parameter int MODE_IDX = 73,
    localparam int AW = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [NUM_REGS];

    // Reset copies the live defaults; afterwards, record mode writes single entries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) mem[i] <= reg_default(i, MODE_IDX);
        end else if (we) begin
            mem[wr_idx] <= wr_data;
        end
    end

    // Asynchronous read used for the replay substitution.
    always_comb rd_data = mem[rd_idx];
endmodule

// File: rtl/smrf_live_bank.sv
// Module: live register array with change-qualified writes and per-register dirty bits.
// Assumes wr_idx is in range whenever wr_en is high; set of a dirty bit wins over its clear.
module smrf_live_bank
    import smrf_pkg::*;
#(
    parameter int NUM_REGS = 96,
    parameter int MODE_IDX = 73,
    localparam int AW = $clog2(NUM_REGS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_idx,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [NUM_REGS-1:0] dirty_clr,
    input  logic [AW-1:0]       rd_idx,
    output logic [DATA_W-1:0]   rd_data,
    output logic [NUM_REGS-1:0] dirty,
    output logic                changed
);
    logic [DATA_W-1:0]   regs [NUM_REGS];
    logic [NUM_REGS-1:0] set_vec;

    // A write counts only when the new value differs from the stored one.
    always_comb changed = wr_en && (regs[wr_idx] != wr_data);

    // Load defaults on reset, then store changed values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) regs[i] <= reg_default(i, MODE_IDX);
        end else if (changed) begin
            regs[wr_idx] <= wr_data;
        end
    end

    // One dirty flop per register: set on change, otherwise cleared on request.
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_dirty
        always_comb set_vec[g] = changed && (wr_idx == AW'(g));
        always_ff @(posedge clk) begin
            if (!rst_n)            dirty[g] <= 1'b0;
            else if (set_vec[g])   dirty[g] <= 1'b1;
            else if (dirty_clr[g]) dirty[g] <= 1'b0;
        end
    end

    // Combinational read for downstream consumers.
    always_comb rd_data = regs[rd_idx];
endmodule

// File: rtl/shadow_method_regfile.sv
// Module: top of the shadowed method register file. It accepts one method per cycle,
// computes the effective argument from the shadow mode, updates the shadow and live banks,
// and presents the effective argument one cycle later.
// Assumes IDX_W is wide enough to address NUM_REGS and that MODE_IDX < NUM_REGS.
module shadow_method_regfile
    import smrf_pkg::*;
#(
    parameter int NUM_REGS = 96,
    parameter int IDX_W    = 8,
    parameter int MODE_IDX = 73,
    localparam int AW = $clog2(NUM_REGS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [IDX_W-1:0]    in_idx,
    input  logic [DATA_W-1:0]   in_arg,
    output logic                out_valid,
    output logic [IDX_W-1:0]    out_idx,
    output logic [DATA_W-1:0]   out_arg,
    output logic                err,
    output logic [NUM_REGS-1:0] dirty,
    input  logic [NUM_REGS-1:0] dirty_clr,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [DATA_W-1:0]   rd_data
);
    localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NUM_REGS);

    logic              accept, in_range, rd_in_range, shadow_we, mode_we, live_changed;
    logic [AW-1:0]     idx_a;
    logic [DATA_W-1:0] shadow_rd, eff_arg, live_rd;
    logic [DATA_W-1:0] mode_raw;
    shadow_mode_e      mode_cur;

    // Decode the handshake and the range of the index.
    always_comb begin
        accept      = in_valid && in_ready;
        in_range    = {1'b0, in_idx} < LIMIT;
        rd_in_range = {1'b0, rd_idx} < LIMIT;
        idx_a       = in_idx[AW-1:0];
    end

    // Choose the effective argument and the shadow/mode write enables.
    always_comb begin
        eff_arg   = (mode_cur == SHM_REPLAY) ? shadow_rd : in_arg;
        shadow_we = accept && in_range &&
                    (mode_cur == SHM_RECORD || mode_cur == SHM_RECORD_FILT);
        mode_we   = accept && in_range && (in_idx == IDX_W'(MODE_IDX));
    end

    // Ready rises after reset and then stays high: one method per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) in_ready <= 1'b0;
        else        in_ready <= 1'b1;
    end

    // Register the effective argument strobe and the range error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_idx   <= '0;
            out_arg   <= '0;
            err       <= 1'b0;
        end else begin
            out_valid <= accept && in_range;
            err       <= accept && !in_range;
            if (accept && in_range) begin
                out_idx <= in_idx;
                out_arg <= eff_arg;
            end
        end
    end

    smrf_mode_ctl u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mode_we),
        .wr_raw  (in_arg),
        .mode_raw(mode_raw),
        .mode    (mode_cur)
    );

    smrf_shadow_bank #(.NUM_REGS(NUM_REGS), .MODE_IDX(MODE_IDX)) u_shadow (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (shadow_we),
        .wr_idx (idx_a),
        .wr_data(in_arg),
        .rd_idx (idx_a),
        .rd_data(shadow_rd)
    );

    smrf_live_bank #(.NUM_REGS(NUM_REGS), .MODE_IDX(MODE_IDX)) u_live (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (accept && in_range),
        .wr_idx   (idx_a),
        .wr_data  (eff_arg),
        .dirty_clr(dirty_clr),
        .rd_idx   (rd_idx[AW-1:0]),
        .rd_data  (live_rd),
        .dirty    (dirty),
        .changed  (live_changed)
    );

    // Out-of-range reads return zero.
    always_comb rd_data = rd_in_range ? live_rd : '0;
endmodule

// File: rtl/smrf_checker.sv
// Checker: temporal properties of the shadowed method register file, bound to its top.
// Assumes the inputs carry known values whenever in_valid is high.
module smrf_checker #(
    parameter int NUM_REGS = 96,
    parameter int IDX_W    = 8,
    parameter int MODE_IDX = 73
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                in_ready,
    input logic [IDX_W-1:0]    in_idx,
    input logic [31:0]         in_arg,
    input logic                out_valid,
    input logic                err,
    input logic [NUM_REGS-1:0] dirty,
    input logic [31:0]         mode_raw,
    input logic [1:0]          mode,
    input logic                shadow_we
);
    // R7
    out_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid && in_ready && (in_idx < IDX_W'(NUM_REGS))));

    // R8
    err_after_bad_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(in_valid && in_ready && (in_idx >= IDX_W'(NUM_REGS))));

    // R8
    err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(err && out_valid));

    // R6
    mode_raw_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_idx == IDX_W'(MODE_IDX)) |=> (mode_raw == $past(in_arg)));

    // R3
    bypass_no_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2) |-> !shadow_we);

    // R5
    dirty_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(dirty & ~$past(dirty))) |-> $past(in_valid && in_ready));

    // R10
    ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> in_ready);
endmodule

bind shadow_method_regfile smrf_checker #(
    .NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .MODE_IDX(MODE_IDX)
) u_smrf_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_idx   (in_idx),
    .in_arg   (in_arg),
    .out_valid(out_valid),
    .err      (err),
    .dirty    (dirty),
    .mode_raw (mode_raw),
    .mode     (mode_cur),
    .shadow_we(shadow_we)
);

// File: tb/shadow_method_regfile_bench.sv
module shadow_method_regfile_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NR = 96;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [7:0]    in_idx = '0;
    logic [31:0]   in_arg = '0;
    logic          out_valid;
    logic [7:0]    out_idx;
    logic [31:0]   out_arg;
    logic          err;
    logic [NR-1:0] dirty;
    logic [NR-1:0] dirty_clr = '0;
    logic [7:0]    rd_idx = '0;
    logic [31:0]   rd_data;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    shadow_method_regfile u_shadow_method_regfile (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_idx(in_idx), .in_arg(in_arg), .out_valid(out_valid), .out_idx(out_idx),
        .out_arg(out_arg), .err(err), .dirty(dirty), .dirty_clr(dirty_clr),
        .rd_idx(rd_idx), .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Vector fields: index, raw argument, expect error, expected effective argument.
    localparam int NV = 18;
    localparam logic [72:0] VEC [NV] = '{
        {8'd5,   32'd111, 1'b0, 32'd111},        // R2 record
        {8'd6,   32'd222, 1'b0, 32'd222},        // R2 record
        {8'd73,  32'd2,   1'b0, 32'd2},          // R6 mode -> bypass (shadow73 = 2)
        {8'd5,   32'd333, 1'b0, 32'd333},        // R3 bypass, shadow5 stays 111
        {8'd73,  32'd3,   1'b0, 32'd3},          // R6 mode -> replay, shadow73 stays 2
        {8'd5,   32'd999, 1'b0, 32'd111},        // R4 replay returns recorded value
        {8'd6,   32'd0,   1'b0, 32'd222},        // R4 replay, equal to live (R5)
        {8'd7,   32'd5,   1'b0, 32'hC0DE0007},   // R4 replay of reset copy (R1)
        {8'd73,  32'd1,   1'b0, 32'd2},          // R6 raw 1 loads mode, live gets replayed 2
        {8'd8,   32'd444, 1'b0, 32'd444},        // R2 record-with-filter
        {8'd73,  32'd3,   1'b0, 32'd3},          // R6 replay again, shadow73 = 3
        {8'd8,   32'd0,   1'b0, 32'd444},        // R4 replay of filtered record
        {8'd73,  32'd7,   1'b0, 32'd3},          // R6 raw 7 -> acts as bypass
        {8'd8,   32'd555, 1'b0, 32'd555},        // R6 unknown mode behaves as R3
        {8'd200, 32'd1,   1'b1, 32'd0},          // R8 far out of range
        {8'd96,  32'd1,   1'b1, 32'd0},          // R8 first illegal index
        {8'd95,  32'd12,  1'b0, 32'd12},         // R7 last legal index
        {8'd73,  32'd0,   1'b0, 32'd0}           // R6 back to record
    };

    task automatic check(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One method, presented for a single cycle; returns at the falling edge after the capture edge.
    task automatic send(input logic [7:0] idx, input logic [31:0] arg, input logic [NR-1:0] clr);
        @(negedge clk);
        in_valid = 1'b1; in_idx = idx; in_arg = arg; dirty_clr = clr; rd_idx = idx;
        @(negedge clk);
        in_valid = 1'b0; dirty_clr = '0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin : watchdog
        while (cycles < 20000) begin
            @(posedge clk);
            cycles++;
        end
        tests++; fails++;
        $display("FAIL watchdog actual=%0d expected=<20000", cycles);
        finish_run();
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 / R10 reset state
        check(in_ready == 1'b1, "R10 ready", 96'(in_ready), 96'd1);
        check(dirty == '0, "R1 dirty", 96'(dirty), 96'd0);
        check(!out_valid && !err, "R1 strobes", 96'({out_valid, err}), 96'd0);
        for (int k = 0; k < 4; k++) begin
            rd_idx = 8'(k * 30 + 4);
            #1;
            check(rd_data == 32'hC0DE0000 + 32'(k * 30 + 4), "R1 default",
                  96'(rd_data), 96'(32'hC0DE0000 + 32'(k * 30 + 4)));
        end
        rd_idx = 8'd73; #1;
        check(rd_data == 32'd0, "R1 mode default", 96'(rd_data), 96'd0);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            logic [7:0]  vi;
            logic [31:0] va, ve;
            logic        verr;
            {vi, va, verr, ve} = VEC[v];
            send(vi, va, '0);
            if (verr) begin
                check(err && !out_valid, "R8 error pulse", 96'({err, out_valid}), 96'b10);
                check(rd_data == 32'd0, "R8 no state", 96'(rd_data), 96'd0);
            end else begin
                check(out_valid && !err, "R7 strobe", 96'({out_valid, err}), 96'b10);
                check(out_idx == vi, "R7 index", 96'(out_idx), 96'(vi));
                check(out_arg == ve, "R7 effective arg", 96'(out_arg), 96'(ve));
                check(rd_data == ve, "R5 live value", 96'(rd_data), 96'(ve));
            end
        end

        // R8 pulse lasts one cycle
        send(8'd150, 32'd9, '0);
        check(err == 1'b1, "R8 pulse high", 96'(err), 96'd1);
        @(negedge clk);
        check(err == 1'b0, "R8 pulse one cycle", 96'(err), 96'd0);

        // R9 clear all dirty bits
        @(negedge clk); dirty_clr = '1;
        @(negedge clk); dirty_clr = '0;
        check(dirty == '0, "R9 clear all", 96'(dirty), 96'd0);

        // R5 equal value: no live change, no dirty
        send(8'd10, 32'hC0DE000A, '0);
        check(dirty == '0, "R5 equal no dirty", 96'(dirty), 96'd0);
        check(rd_data == 32'hC0DE000A, "R5 equal live", 96'(rd_data), 96'hC0DE000A);

        // R5 different value sets exactly one dirty bit
        send(8'd10, 32'd77, '0);
        check(dirty == (NR'(1) << 10), "R5 dirty set", 96'(dirty), 96'(NR'(1) << 10));

        // R9 per-bit clear
        @(negedge clk); dirty_clr = NR'(1) << 10;
        @(negedge clk); dirty_clr = '0;
        check(dirty == '0, "R9 bit clear", 96'(dirty), 96'd0);

        // R9 set wins over clear in the same cycle
        send(8'd11, 32'd88, NR'(1) << 11);
        check(dirty[11] == 1'b1, "R9 set over clear", 96'(dirty[11]), 96'd1);

        // R7 back-to-back methods, then R4 replay of the second recorded value
        @(negedge clk);
        in_valid = 1'b1; in_idx = 8'd12; in_arg = 32'd1;
        @(negedge clk);
        check(out_valid && out_arg == 32'd1, "R7 b2b first", 96'(out_arg), 96'd1);
        in_arg = 32'd2;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid && out_arg == 32'd2, "R7 b2b second", 96'(out_arg), 96'd2);
        send(8'd73, 32'd3, '0);
        send(8'd12, 32'd50, '0);
        check(out_arg == 32'd2, "R4 replay after b2b", 96'(out_arg), 96'd2);

        finish_run();
    end
endmodule